// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block merges eight interrupt request lines into one interrupt output for a processor. Each line can be edge-triggered or level-triggered. Lines that are pending and not masked compete on priority with the levels already in service. The interrupt output is raised only when a pending line outranks everything in service. When the processor acknowledges, the block returns an 8-bit vector: a programmable base plus the number of the winning line. It then marks that line in service, unless automatic end-of-interrupt is enabled.

Software sets up the block through a simple synchronous write port. The port holds a mask byte, a per-line trigger-mode byte, the vector base, a mode byte (automatic end-of-interrupt, rotating priority) and an end-of-interrupt command. The command either names a level or clears the highest-ranked in-service level. Priority is either fixed, with line 0 highest and line 7 lowest, or rotating. In rotating mode, a level whose service ends drops to the lowest rank. If an acknowledge finds no winning request, for example because the request vanished before the acknowledge, the block answers with the line-7 vector and leaves the in-service state untouched.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the interrupt output is 0 and the vector-valid output is 0. All lines are masked and edge-triggered, the vector base is 0, both modes are off, nothing is in service, and priority is fixed.
- R2: A write with cfg_we=1 uses cfg_addr as follows: 0 is the mask (bit=1 masks the line), 1 is trigger mode, 2 is the vector base, 3 is the mode byte and 4 is the end-of-interrupt command. Addresses 5 to 7 have no effect. A new setting takes effect in the cycle after the write. Unmasking a line whose request is still pending raises the interrupt output.
- R3: For a line with trigger bit 0 (edge), a sampled low-to-high transition latches a request. The request clears when that line wins an acknowledge, or when its input is sampled low.
- R4: For a line with trigger bit 1 (level), the request bit follows the input as sampled on each clock, and an acknowledge does not clear it.
- R5: The interrupt output is 1 exactly when some unmasked pending line ranks strictly higher than every in-service level. Under fixed priority, line n has rank n, and 0 is the highest rank.
- R6: When ack is sampled high, the next cycle shows vec_valid=1 with vec_out = base + line, taken modulo 256. Without automatic end-of-interrupt, the winning line is then in service. vec_valid is 0 in every other cycle.
- R7: If an acknowledge finds no line that would raise the interrupt output, vec_out = base + 7 and the in-service state is unchanged. In particular, line 7 is not marked in service.
- R8: An end-of-interrupt command with bit 3 = 1 clears only the in-service level given in bits 2:0.
- R9: An end-of-interrupt command with bit 3 = 0 clears the highest-ranked in-service level.
- R10: With mode bit 0 set, an acknowledge returns the vector but does not set any in-service level.
- R11: With mode bit 1 set, the priority rotates. A level cleared from service by an end-of-interrupt command, or a level acknowledged under automatic end-of-interrupt, becomes the lowest rank; the next line above it becomes the highest.
- R12: When an acknowledge and an end-of-interrupt command fall in the same cycle, the acknowledge is resolved against the state held before that cycle. The command then clears from that same state. If both move the rotation, the acknowledge's update is the one kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Interrupt request lines, bit n = line n |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| ack | input | 1 | Interrupt acknowledge, one cycle per acknowledge |
| int_req | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector of the last acknowledge |
| vec_valid | output | 1 | vec_out is fresh this cycle |

## Verification
The case that needs care is an acknowledge and an end-of-interrupt command landing in the same cycle. Both change the in-service state, and under rotation both can move the priority pointer. The bench provokes this both in a directed step, where a higher line and a lower line are in play, and through constrained random traffic that often overlaps acknowledges with command writes. A bench reference model judges each cycle: it resolves the acknowledge from the state held before the cycle, applies the command's clear to that same state, and lets the acknowledge's rotation win. Any other ordering shows up as a wrong vector or a wrong interrupt level in the following cycles.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int LINES = 8;
  localparam int LW    = $clog2(LINES);
  localparam int RW    = LW + 1;
  localparam int VW    = 8;
  localparam int AW    = 3;

  typedef logic [LW-1:0]    line_t;
  typedef logic [VW-1:0]    vec_t;
  typedef logic [LINES-1:0] lines_t;

  typedef struct packed {
    logic rotate;
    logic auto_eoi;
  } mode_t;

  // line holding rank r when 'low' is the lowest-ranked line
  function automatic line_t line_at(line_t low, line_t r);
    return line_t'(low + r + line_t'(1));
  endfunction

  function automatic vec_t vec_of(vec_t base, line_t ln);
    return vec_t'(base + vec_t'(ln));
  endfunction

  function automatic lines_t onehot(line_t ln);
    lines_t v;
    v = '0;
    v[ln] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/irqc_capture.sv
module irqc_capture
  import irqc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  lines_t irq_in,
  input  lines_t lvl_mode,
  input  lines_t ack_clr,
  output lines_t req
);
  lines_t irq_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_prev <= '0;
    else        irq_prev <= irq_in;
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n)                         req[i] <= 1'b0;
      else if (lvl_mode[i])               req[i] <= irq_in[i];
      else if (!irq_in[i])                req[i] <= 1'b0;
      else if (!irq_prev[i])              req[i] <= 1'b1;
      else if (ack_clr[i])                req[i] <= 1'b0;
    end

    // R3: a latched edge request stays while the line is high and not acknowledged
    p_edge_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!lvl_mode[i] && req[i] && irq_in[i] && !ack_clr[i]) |=> req[i]);
  end
endmodule

// File: rtl/irqc_resolve.sv
module irqc_resolve
  import irqc_pkg::*;
(
  input  lines_t pend,
  input  lines_t isr,
  input  line_t  low,
  output logic   fire,
  output line_t  win,
  output logic   isr_any,
  output line_t  isr_top
);
  logic [RW-1:0] wrank, irank;
  logic          pend_any;

  always_comb begin
    win      = '0;
    isr_top  = '0;
    wrank    = RW'(LINES);
    irank    = RW'(LINES);
    pend_any = 1'b0;
    isr_any  = 1'b0;
    // scan from lowest rank to highest so the highest rank is kept last
    for (int r = LINES - 1; r >= 0; r--) begin
      if (pend[line_at(low, line_t'(r))]) begin
        win      = line_at(low, line_t'(r));
        wrank    = RW'(r);
        pend_any = 1'b1;
      end
      if (isr[line_at(low, line_t'(r))]) begin
        isr_top = line_at(low, line_t'(r));
        irank   = RW'(r);
        isr_any = 1'b1;
      end
    end
    fire = pend_any && (wrank < irank);
  end
endmodule

// File: rtl/irqc_service.sv
module irqc_service
  import irqc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ack,
  input  logic   fire,
  input  line_t  win,
  input  logic   isr_any,
  input  line_t  isr_top,
  input  mode_t  mode,
  input  vec_t   base,
  input  logic   eoi_we,
  input  logic   eoi_spec,
  input  line_t  eoi_lvl,
  output lines_t isr,
  output line_t  low_ptr,
  output vec_t   vec_out,
  output logic   vec_valid
);
  lines_t eoi_clr, ack_set;
  logic   eoi_done;
  line_t  eoi_line;
  line_t  low_nxt;

  always_comb begin
    eoi_clr  = '0;
    eoi_done = 1'b0;
    eoi_line = eoi_lvl;
    if (eoi_we) begin
      if (eoi_spec) begin
        eoi_done = isr[eoi_lvl];
      end else begin
        eoi_done = isr_any;
        eoi_line = isr_top;
      end
      if (eoi_done) eoi_clr = onehot(eoi_line);
    end
    ack_set = (ack && fire && !mode.auto_eoi) ? onehot(win) : '0;
    low_nxt = low_ptr;
    if (mode.rotate && eoi_done) low_nxt = eoi_line;
    if (mode.rotate && ack && fire && mode.auto_eoi) low_nxt = win;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr       <= '0;
      low_ptr   <= line_t'(LINES - 1);
      vec_out   <= '0;
      vec_valid <= 1'b0;
    end else begin
      isr       <= (isr & ~eoi_clr) | ack_set;
      low_ptr   <= low_nxt;
      vec_valid <= ack;
      if (ack) vec_out <= fire ? vec_of(base, win) : vec_of(base, line_t'(LINES - 1));
    end
  end

  // R7: a spurious acknowledge leaves the in-service state alone
  p_spur_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !fire && !eoi_we) |=> (isr == $past(isr)));
  // R6: an acknowledged winner is in service afterwards
  p_isr_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && fire && !mode.auto_eoi) |=> isr[$past(win)]);
  // R10: automatic end-of-interrupt never sets an in-service level
  p_auto_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && mode.auto_eoi && !eoi_we) |=> (isr == $past(isr)));
  // R8: a specific command leaves every other level as it was
  p_spec_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_we && eoi_spec && !ack) |=> ((isr | onehot($past(eoi_lvl))) == ($past(isr) | onehot($past(eoi_lvl)))));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irqc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    irq_in,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [7:0]    cfg_wdata,
  input  logic          ack,
  output logic          int_req,
  output logic [7:0]    vec_out,
  output logic          vec_valid
);
  localparam logic [AW-1:0] A_MASK = AW'(0);
  localparam logic [AW-1:0] A_TRIG = AW'(1);
  localparam logic [AW-1:0] A_BASE = AW'(2);
  localparam logic [AW-1:0] A_MODE = AW'(3);
  localparam logic [AW-1:0] A_EOI  = AW'(4);

  lines_t mask_r, lvl_r, req, pend, isr, ack_clr;
  vec_t   base_r;
  mode_t  mode_r;
  line_t  low_ptr, eff_low, win, isr_top;
  logic   fire, isr_any, eoi_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_r <= '1;
      lvl_r  <= '0;
      base_r <= '0;
      mode_r <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        A_MASK:  mask_r <= cfg_wdata;
        A_TRIG:  lvl_r  <= cfg_wdata;
        A_BASE:  base_r <= cfg_wdata;
        A_MODE:  mode_r <= mode_t'(cfg_wdata[1:0]);
        default: ;
      endcase
    end
  end

  assign eoi_we  = cfg_we && (cfg_addr == A_EOI);
  assign pend    = req & ~mask_r;
  assign eff_low = mode_r.rotate ? low_ptr : line_t'(LINES - 1);
  assign ack_clr = (ack && fire) ? (onehot(win) & ~lvl_r) : '0;
  assign int_req = fire;

  irqc_capture u_cap (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .lvl_mode(lvl_r),
    .ack_clr(ack_clr), .req(req)
  );

  irqc_resolve u_res (
    .pend(pend), .isr(isr), .low(eff_low),
    .fire(fire), .win(win), .isr_any(isr_any), .isr_top(isr_top)
  );

  irqc_service u_svc (
    .clk(clk), .rst_n(rst_n), .ack(ack), .fire(fire), .win(win),
    .isr_any(isr_any), .isr_top(isr_top), .mode(mode_r), .base(base_r),
    .eoi_we(eoi_we), .eoi_spec(cfg_wdata[3]), .eoi_lvl(cfg_wdata[LW-1:0]),
    .isr(isr), .low_ptr(low_ptr), .vec_out(vec_out), .vec_valid(vec_valid)
  );

  // R6: one valid vector cycle per acknowledge
  p_ack_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> vec_valid);
  p_no_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> !vec_valid);
  // R5: the interrupt output needs an unmasked pending line
  p_int_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> (pend != '0));
  // R2: a masked line alone never raises the interrupt output
  p_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_r == '1) |-> !int_req);
endmodule

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] irq_in;
  logic       cfg_we;
  logic [2:0] cfg_addr;
  logic [7:0] cfg_wdata;
  logic       ack;
  logic       int_req;
  logic [7:0] vec_out;
  logic       vec_valid;

  always #2 clk = ~clk;

  irq_prio_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .ack(ack),
    .int_req(int_req), .vec_out(vec_out), .vec_valid(vec_valid)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bit [7:0] m_prev, m_req, m_mask, m_lvl, m_base, m_isr;
  bit       m_auto, m_rot;
  bit [2:0] m_low;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // walk from the line just above 'low' round to 'low'
  task automatic mresolve(input bit [7:0] pend, input bit [7:0] isr, input bit [2:0] low,
                          output bit fire, output bit [2:0] win,
                          output bit iany, output bit [2:0] itop);
    int prank = 99, irank = 99;
    win = 0; itop = 0; iany = 0;
    for (int k = 1; k <= 8; k++) begin
      int ln = (int'(low) + k) % 8;
      if (pend[ln] && prank == 99) begin prank = k; win = 3'(ln); end
      if (isr[ln] && irank == 99) begin irank = k; itop = 3'(ln); iany = 1; end
    end
    fire = (prank != 99) && (prank < irank);
  endtask

  task automatic model_reset();
    m_prev = 0; m_req = 0; m_mask = 8'hFF; m_lvl = 0; m_base = 0;
    m_isr = 0; m_auto = 0; m_rot = 0; m_low = 3'd7;
  endtask

  task automatic step(input bit [7:0] irq, input bit we, input bit [2:0] a,
                      input bit [7:0] d, input bit ak, input string tag);
    bit f, ia, f2, ia2;
    bit [2:0] w, it, w2, it2, nlow;
    bit [7:0] clr, set, nreq, expv;
    @(negedge clk);
    irq_in = irq; cfg_we = we; cfg_addr = a; cfg_wdata = d; ack = ak;
    mresolve(m_req & ~m_mask, m_isr, m_rot ? m_low : 3'd7, f, w, ia, it);
    expv = f ? 8'(m_base + w) : 8'(m_base + 8'd7);
    clr = 0; set = 0; nlow = m_low;
    if (we && a == 3'd4) begin
      if (d[3]) begin
        if (m_isr[d[2:0]]) begin clr[d[2:0]] = 1; if (m_rot) nlow = d[2:0]; end
      end else if (ia) begin
        clr[it] = 1; if (m_rot) nlow = it;
      end
    end
    if (ak && f) begin
      if (!m_auto) set[w] = 1;
      else if (m_rot) nlow = w;
    end
    for (int i = 0; i < 8; i++) begin
      if (m_lvl[i])                      nreq[i] = irq[i];
      else if (!irq[i])                  nreq[i] = 0;
      else if (!m_prev[i])               nreq[i] = 1;
      else if (ak && f && w == 3'(i))    nreq[i] = 0;
      else                               nreq[i] = m_req[i];
    end
    m_req = nreq; m_prev = irq; m_isr = (m_isr & ~clr) | set; m_low = nlow;
    if (we) begin
      case (a)
        3'd0: m_mask = d;
        3'd1: m_lvl  = d;
        3'd2: m_base = d;
        3'd3: begin m_auto = d[0]; m_rot = d[1]; end
        default: ;
      endcase
    end
    @(posedge clk); #1;
    mresolve(m_req & ~m_mask, m_isr, m_rot ? m_low : 3'd7, f2, w2, ia2, it2);
    check({tag, " int_req"}, 32'(int_req), 32'(f2));
    check({tag, " vec_valid"}, 32'(vec_valid), 32'(ak));
    if (ak) check({tag, " vec_out"}, 32'(vec_out), 32'(expv));
  endtask

  task automatic idle(input bit [7:0] irq, input string tag);
    step(irq, 0, 0, 0, 0, tag);
  endtask
  task automatic wr(input bit [7:0] irq, input bit [2:0] a, input bit [7:0] d, input string tag);
    step(irq, 1, a, d, 0, tag);
  endtask
  task automatic acknowledge(input bit [7:0] irq, input string tag);
    step(irq, 0, 0, 0, 1, tag);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    bit [7:0] ri;
    rst_n = 0; irq_in = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; ack = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    check("R1 int_req after reset", 32'(int_req), 0);
    check("R1 vec_valid after reset", 32'(vec_valid), 0);

    // R2: masked request stays silent, unmask raises it
    wr(8'h00, 3'd2, 8'h08, "R2 base write");
    idle(8'h08, "R2 masked edge");
    idle(8'h08, "R2 masked hold");
    wr(8'h08, 3'd5, 8'h00, "R2 ignored address");
    wr(8'h08, 3'd0, 8'h00, "R2 unmask pending");
    // R6 / R3: acknowledge line 3, edge request then clears
    acknowledge(8'h08, "R6 vector line3");
    idle(8'h08, "R3 edge cleared by ack");
    wr(8'h00, 3'd4, 8'h00, "R9 nonspecific eoi");
    // R5: line 2 then line 5, lower line blocked while 2 in service
    idle(8'h24, "R5 two edges");
    acknowledge(8'h24, "R5 ack winner line2");
    idle(8'h24, "R5 line5 blocked");
    wr(8'h24, 3'd4, 8'h0A, "R8 specific eoi line2");
    acknowledge(8'h24, "R6 vector line5");
    wr(8'h24, 3'd4, 8'h00, "R9 clear line5");
    // R7: request vanishes before acknowledge
    idle(8'h00, "R7 prep");
    idle(8'h02, "R7 raise line1");
    idle(8'h00, "R7 drop line1");
    acknowledge(8'h00, "R7 spurious vector");
    idle(8'h80, "R7 line7 not in service");
    idle(8'h80, "R7 line7 pending");
    acknowledge(8'h80, "R7 real line7");
    wr(8'h00, 3'd4, 8'h00, "R9 clear line7");
    // R4: level line 4
    wr(8'h00, 3'd1, 8'h10, "R4 level mode");
    idle(8'h10, "R4 level raise");
    acknowledge(8'h10, "R4 ack level");
    idle(8'h10, "R4 level held in service");
    wr(8'h10, 3'd4, 8'h0C, "R8 specific eoi line4");
    idle(8'h10, "R4 level reasserts");
    idle(8'h00, "R4 level drop");
    // R10: auto end-of-interrupt
    wr(8'h00, 3'd3, 8'h01, "R10 auto mode");
    idle(8'h10, "R10 level raise");
    acknowledge(8'h10, "R10 ack auto");
    idle(8'h10, "R10 still requesting");
    idle(8'h00, "R10 drop");
    // R11: rotating priority
    wr(8'h00, 3'd1, 8'h00, "R11 all edge");
    wr(8'h00, 3'd3, 8'h02, "R11 rotate mode");
    idle(8'h01, "R11 raise line0");
    acknowledge(8'h01, "R11 ack line0");
    wr(8'h00, 3'd4, 8'h00, "R11 eoi rotates");
    idle(8'h03, "R11 raise 0 and 1");
    acknowledge(8'h03, "R11 line1 wins");
    // R12: acknowledge and command together
    step(8'h03, 1, 3'd4, 8'h00, 1, "R12 ack with eoi");
    idle(8'h03, "R12 after overlap");
    wr(8'h00, 3'd4, 8'h00, "R12 cleanup");
    wr(8'h00, 3'd3, 8'h03, "R12 auto rotate");
    idle(8'h44, "R12 raise 2 and 6");
    step(8'h44, 1, 3'd4, 8'h08, 1, "R12 auto ack with eoi");
    idle(8'h44, "R12 after auto overlap");

    // constrained random traffic
    void'($urandom(32'd20240611));
    ri = 0;
    for (int n = 0; n < 4000; n++) begin
      bit we, ak;
      bit [2:0] a;
      bit [7:0] d;
      ri = ri ^ 8'($urandom & $urandom & $urandom);
      we = ($urandom % 5) == 0;
      a  = 3'($urandom % 8);
      d  = 8'($urandom);
      if (a == 3'd0 && ($urandom % 2) == 0) d = 8'($urandom & $urandom);
      ak = ($urandom % 4) == 0;
      step(ri, we, a, d, ak, "R12 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule